// File: doc/BRIEF.md
# Boot Bank and In-System Programming Mode Controller

This block decides which on-chip program memory bank the CPU fetches from and when in-system programming (ISP) takes effect. The CPU writes an 8-bit chip-control byte. Setting the arm bit requests ISP, but nothing switches at once. The switch happens only when the CPU later leaves idle on a wake strobe, which a timer interrupt normally produces. On that wake the block moves execution from the 32 KB application bank to the 4 KB loader bank and pulses a program-counter clear, so that the first interrupt return resumes at address 0x00 of the loader bank.

Writing a specific three-bit key into the control byte starts a software reset. The reset acts like an external reset: it drives a reset pulse of fixed length, clears the control byte and idle state, and returns execution to the application bank. The external reset input has the same clearing effect on the mode state.

Top module: `isp_boot_ctrl`

## Requirements
- R1: After the external reset `rst`, `bank_sel` is 0 (application bank), `ctl_armed` is 0, and `pc_clr` and `sw_rst` are both 0.
- R2: A control write with bit 0 set (and not the reset key) makes `ctl_armed` 1 from the next cycle on, and leaves `bank_sel` unchanged.
- R3: A `wake_stb` is ignored when no `idle_stb` has come before it since the last wake or reset. Bank and `pc_clr` stay unchanged.
- R4: If the block is armed, in the application bank and idle, a `wake_stb` sets `bank_sel` to 1 (loader bank) in the next cycle. In that same cycle `pc_clr` is high for exactly one cycle.
- R5: A wake from idle with the arm bit clear leaves `bank_sel` unchanged and does not pulse `pc_clr`.
- R6: A wake from idle while already in the loader bank does not pulse `pc_clr`, and the bank stays 1.
- R7: A control write with bits 0, 1 and 7 all set (the reset key, e.g. 0x83) raises `sw_rst` from the next cycle for exactly RST_CYCLES cycles (default 4). During the pulse `bank_sel` is 0 and `ctl_armed` is 0.
- R8: A write that has only some of bits 0, 1 and 7 set (e.g. 0x03 or 0x81) does not raise `sw_rst`.
- R9: Control writes that arrive while `sw_rst` is high are ignored: `ctl_armed` is 0 after the pulse ends.
- R10: The external reset, applied while the loader bank is selected and the block is armed, returns `bank_sel` to 0 and clears `ctl_armed`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high external reset |
| ctl_we | input | 1 | Write strobe for the chip-control byte |
| ctl_wdata | input | 8 | Control byte: bit 0 arm, bits 0+1+7 reset key |
| idle_stb | input | 1 | Single-cycle strobe: CPU enters idle |
| wake_stb | input | 1 | Single-cycle strobe: CPU wakes from idle |
| bank_sel | output | 1 | 0 = application bank, 1 = loader bank |
| pc_clr | output | 1 | One-cycle program-counter clear on the switch into the loader bank |
| sw_rst | output | 1 | Software reset pulse, RST_CYCLES cycles long |
| ctl_armed | output | 1 | Current value of the arm bit |

## Verification
The assertions assume that `idle_stb` and `wake_stb` are single-cycle strobes that never arrive in the same cycle, and that `rst` is held high at the first clock edge. The bench drives every strobe and write for exactly one cycle from the falling edge, keeps idle and wake strobes in separate cycles, and asserts reset before any other stimulus. A control write and a wake strobe are never issued together, so the order of bank switch and control clearing is never ambiguous.

// File: rtl/isp_boot_pkg.sv
package isp_boot_pkg;

    typedef enum logic {
        BANK_APP = 1'b0,
        BANK_LDR = 1'b1
    } bank_e;

    typedef struct packed {
        logic       key_hi;   // bit 7
        logic [4:0] spare;    // bits 6..2
        logic       key_lo;   // bit 1
        logic       arm;      // bit 0
    } ctl_t;

    function automatic logic is_reset_key(ctl_t c);
        return c.arm & c.key_lo & c.key_hi;
    endfunction

endpackage

// File: rtl/isp_ctl_reg.sv
module isp_ctl_reg
    import isp_boot_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic busy,
    input  logic clr,
    input  logic we,
    input  ctl_t wdata,
    output ctl_t ctl_q,
    output logic rst_req
);

    assign rst_req = we & ~busy & is_reset_key(wdata);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ctl_q <= '0;
        end else if (we) begin
            ctl_q <= wdata;
        end
    end

    // R9
    writes_blocked_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> !ctl_q.arm);

endmodule

// File: rtl/isp_rst_pulse.sv
module isp_rst_pulse #(
    parameter int RST_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);

    localparam int CW = $clog2(RST_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(RST_CYCLES);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (start && cnt == '0) begin
            cnt <= LOAD;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign busy = (cnt != '0);

    // R7
    pulse_load_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> cnt == LOAD);

endmodule

// File: rtl/isp_bank_fsm.sv
module isp_bank_fsm
    import isp_boot_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clr,
    input  logic  idle_stb,
    input  logic  wake_stb,
    input  logic  armed,
    output bank_e bank_q,
    output logic  pc_clr_q
);

    logic idle_q;
    logic switch_now;

    assign switch_now = wake_stb & idle_q & armed & (bank_q == BANK_APP);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            idle_q   <= 1'b0;
            bank_q   <= BANK_APP;
            pc_clr_q <= 1'b0;
        end else begin
            pc_clr_q <= switch_now;
            if (wake_stb && idle_q) begin
                idle_q <= 1'b0;
            end else if (idle_stb) begin
                idle_q <= 1'b1;
            end
            if (switch_now) begin
                bank_q <= BANK_LDR;
            end
        end
    end

    // R4
    pc_clr_single_chk: assert property (@(posedge clk) disable iff (rst)
        pc_clr_q |=> !pc_clr_q);

    // R4
    pc_clr_bank_chk: assert property (@(posedge clk) disable iff (rst)
        pc_clr_q |-> bank_q == BANK_LDR);

    // R3
    switch_needs_wake_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bank_q == BANK_LDR) |-> $past(wake_stb));

    // R5
    disarmed_wake_chk: assert property (@(posedge clk) disable iff (rst || clr)
        (wake_stb && !armed) |=> (!pc_clr_q && $stable(bank_q)));

    // R6
    no_reswitch_chk: assert property (@(posedge clk) disable iff (rst)
        (bank_q == BANK_LDR && !clr) |=> !pc_clr_q);

endmodule

// File: rtl/isp_boot_ctrl.sv
module isp_boot_ctrl
    import isp_boot_pkg::*;
#(
    parameter int RST_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ctl_we,
    input  logic [7:0] ctl_wdata,
    input  logic       idle_stb,
    input  logic       wake_stb,
    output logic       bank_sel,
    output logic       pc_clr,
    output logic       sw_rst,
    output logic       ctl_armed
);

    ctl_t  ctl_q;
    logic  rst_req;
    logic  busy;
    logic  clr_all;
    bank_e bank_q;

    assign clr_all = rst_req | busy;

    isp_ctl_reg u_ctl (
        .clk     (clk),
        .rst     (rst),
        .busy    (busy),
        .clr     (clr_all),
        .we      (ctl_we),
        .wdata   (ctl_t'(ctl_wdata)),
        .ctl_q   (ctl_q),
        .rst_req (rst_req)
    );

    isp_rst_pulse #(.RST_CYCLES(RST_CYCLES)) u_pulse (
        .clk   (clk),
        .rst   (rst),
        .start (rst_req),
        .busy  (busy)
    );

    isp_bank_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr_all),
        .idle_stb (idle_stb),
        .wake_stb (wake_stb),
        .armed    (ctl_q.arm),
        .bank_q   (bank_q),
        .pc_clr_q (pc_clr)
    );

    assign bank_sel  = (bank_q == BANK_LDR);
    assign sw_rst    = busy;
    assign ctl_armed = ctl_q.arm;

    // R7
    rst_state_chk: assert property (@(posedge clk) disable iff (rst)
        sw_rst |-> (!bank_sel && !ctl_armed && !pc_clr));

    // R8
    key_only_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sw_rst) |-> $past(ctl_we && ctl_wdata[0] && ctl_wdata[1] && ctl_wdata[7]));

endmodule

// File: tb/isp_boot_ctrl_bench.sv
module isp_boot_ctrl_bench;

    localparam int RSTC = 4;

    logic       clk = 1'b0;
    logic       rst;
    logic       ctl_we;
    logic [7:0] ctl_wdata;
    logic       idle_stb;
    logic       wake_stb;
    logic       bank_sel;
    logic       pc_clr;
    logic       sw_rst;
    logic       ctl_armed;

    int n_run  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    isp_boot_ctrl #(.RST_CYCLES(RSTC)) u_isp_boot_ctrl (
        .clk       (clk),
        .rst       (rst),
        .ctl_we    (ctl_we),
        .ctl_wdata (ctl_wdata),
        .idle_stb  (idle_stb),
        .wake_stb  (wake_stb),
        .bank_sel  (bank_sel),
        .pc_clr    (pc_clr),
        .sw_rst    (sw_rst),
        .ctl_armed (ctl_armed)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        ctl_we = 1'b1;
        ctl_wdata = d;
        @(negedge clk);
        ctl_we = 1'b0;
        ctl_wdata = '0;
    endtask

    task automatic idle();
        @(negedge clk);
        idle_stb = 1'b1;
        @(negedge clk);
        idle_stb = 1'b0;
    endtask

    // returns after the negedge following the wake edge
    task automatic wake();
        @(negedge clk);
        wake_stb = 1'b1;
        @(negedge clk);
        wake_stb = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset();
        chk("R1 bank", bank_sel, 0);
        chk("R1 armed", ctl_armed, 0);
        chk("R1 pc_clr", pc_clr, 0);
        chk("R1 sw_rst", sw_rst, 0);
    endtask

    task automatic t_arm_and_switch();
        do_reset();
        wr(8'h01);
        chk("R2 armed", ctl_armed, 1);
        chk("R2 bank", bank_sel, 0);
        wake();
        chk("R3 bank", bank_sel, 0);
        chk("R3 pc_clr", pc_clr, 0);
        idle();
        wake();
        chk("R4 bank", bank_sel, 1);
        chk("R4 pc_clr", pc_clr, 1);
        @(negedge clk);
        chk("R4 pc_clr single", pc_clr, 0);
        chk("R4 bank held", bank_sel, 1);
        idle();
        wake();
        chk("R6 pc_clr", pc_clr, 0);
        chk("R6 bank", bank_sel, 1);
        do_reset();
        chk("R10 bank", bank_sel, 0);
        chk("R10 armed", ctl_armed, 0);
    endtask

    task automatic t_disarmed_wake();
        do_reset();
        wr(8'h40);
        idle();
        wake();
        chk("R5 bank", bank_sel, 0);
        chk("R5 pc_clr", pc_clr, 0);
    endtask

    task automatic t_sw_reset();
        int highs;
        do_reset();
        wr(8'h01);
        idle();
        wake();
        chk("R4 pre-key bank", bank_sel, 1);
        @(negedge clk);
        ctl_we = 1'b1;
        ctl_wdata = 8'h83;
        @(negedge clk);
        ctl_we = 1'b0;
        ctl_wdata = '0;
        chk("R7 first", sw_rst, 1);
        chk("R7 bank", bank_sel, 0);
        chk("R7 armed", ctl_armed, 0);
        highs = 1;
        for (int i = 0; i < 8; i++) begin
            if (i == 0) begin
                ctl_we = 1'b1;          // R9 write during pulse
                ctl_wdata = 8'h01;
            end
            @(negedge clk);
            ctl_we = 1'b0;
            ctl_wdata = '0;
            if (sw_rst) highs++;
        end
        chk("R7 length", highs, RSTC);
        chk("R9 armed", ctl_armed, 0);
        chk("R7 bank after", bank_sel, 0);
    endtask

    task automatic t_partial_key();
        do_reset();
        wr(8'h03);
        chk("R8 03", sw_rst, 0);
        wr(8'h81);
        chk("R8 81", sw_rst, 0);
        wr(8'h82);
        chk("R8 82", sw_rst, 0);
    endtask

    initial begin
        rst = 1'b1;
        ctl_we = 1'b0;
        ctl_wdata = '0;
        idle_stb = 1'b0;
        wake_stb = 1'b0;
        t_reset_state();
        t_arm_and_switch();
        t_disarmed_wake();
        t_sw_reset();
        t_partial_key();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule